// File: doc/BRIEF.md
# Instruction Prefix and Operand-Width Decoder

This block sits at the front of an instruction decoder. It takes an instruction byte stream one byte per cycle, together with a mode input that selects 64-bit long mode or 32-bit compatibility mode. It collects the legacy prefix bytes and the optional register-extension prefix. When it reaches the opcode byte, it reports the effective operand width, the effective address width, the four extension bits, whether the opcode belongs to the stack class, and whether it is a byte-sized operation. It also forms the value that a general register would hold after the instruction writes its result. That value is built from the old register contents and the raw result, according to the decoded width.

The control is a two-state machine. In `S_SCAN` no extension prefix is pending. In `S_EXTPEND` an extension prefix has been taken in, and the next byte must be the opcode for that prefix to count. The machine makes these transitions:
- **scan_legacy**: `S_SCAN` to `S_SCAN` on a legacy prefix.
- **scan_ext**: `S_SCAN` to `S_EXTPEND` on an extension prefix, which is accepted in long mode only.
- **pend_replace**: `S_EXTPEND` to `S_EXTPEND` on a further extension prefix, which replaces the earlier one.
- **pend_drop**: `S_EXTPEND` to `S_SCAN` on a legacy prefix, which discards the pending extension prefix.
- **finish**: any state to `S_SCAN` on the opcode byte. This transition raises `done` and clears all prefix state for the next instruction.

Top module: `insn_size_decoder`

## Requirements
- R1: After reset, `done` is 0, and `opcode`, `op_size`, `addr_size`, the four extension bits, `stack_op` and `byte_op` are all 0.
- R2: In long mode, with no size prefix and no extension prefix, an ordinary opcode gets `op_size` = 1 (32-bit) and `addr_size` = 2 (64-bit). The width encoding is 0 = 16-bit, 1 = 32-bit, 2 = 64-bit.
- R3: In long mode, an extension prefix with bit 3 (W) set gives `op_size` = 2. This holds even when byte 0x66 is also present.
- R4: In long mode, byte 0x66 without W set gives `op_size` = 0.
- R5: An extension prefix takes effect only when it is the byte directly before the opcode. If any legacy prefix follows it, the decoder discards it: all four extension bits read 0 and W has no effect. The legacy prefix bytes are 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3.
- R6: In compatibility mode, bytes 0x40–0x4F are opcodes and complete an instruction. The extension bits are always 0. `op_size` is 1 by default and 0 with 0x66. `addr_size` is 1 by default and 0 with 0x67.
- R7: In long mode, the stack opcodes (0x50–0x5F, 0x68, 0x6A, 0x8F, 0x9C, 0x9D) default to `op_size` = 2. An extension prefix with W = 0 leaves them at 2. With 0x66 and W = 0 they give 0.
- R8: In long mode, the extension prefix byte has the form 0x4 followed by four bits, and those bits drive `ext_w`, `ext_r`, `ext_x` and `ext_b` from bit 3 down to bit 0. When two extension prefixes arrive back to back, the later one wins.
- R9: In long mode, byte 0x67 gives `addr_size` = 1.
- R10: `done` is high for exactly the cycle after the cycle in which the opcode byte is accepted (`byte_vld` = 1). It stays low after prefix bytes and idle cycles. Fields are only updated together with `done`.
- R11: `wb_out` shows the register value after the write. A 64-bit result replaces the whole register. A 32-bit result is zero-extended into the upper half. A 16-bit result replaces only bits 15:0, and a byte operation replaces only bits 7:0; the remaining bits keep `wb_old`. The byte operations are: 0x88, 0x8A, 0xC6, 0xB0–0xB7, and opcodes below 0x40 whose low three bits are 0, 2 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | `byte_in` holds a stream byte this cycle |
| byte_in | input | 8 | Instruction stream byte |
| long_mode | input | 1 | 1 = 64-bit long mode, 0 = compatibility mode |
| wb_old | input | 64 | Destination register value before the write |
| wb_res | input | 64 | Raw result of the operation |
| done | output | 1 | One-cycle pulse; the decoded fields are fresh |
| opcode | output | 8 | Opcode byte of the decoded instruction |
| op_size | output | 2 | Operand width: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit |
| addr_size | output | 2 | Address width, same encoding as `op_size` |
| ext_w | output | 1 | Extension bit W |
| ext_r | output | 1 | Extension bit R (ModRM reg field) |
| ext_x | output | 1 | Extension bit X (SIB index) |
| ext_b | output | 1 | Extension bit B (base / rm) |
| stack_op | output | 1 | Opcode is in the stack class |
| byte_op | output | 1 | Opcode is a byte-sized operation |
| wb_out | output | 64 | Register value after the write |

## Verification
The stimulus covers the following patterns:
- **Plain opcodes, in both modes.** These separate the 32-bit default from the widened stack default and from compatibility-mode decoding. A 0x40 byte is expected to end the instruction in compatibility mode, but to wait for an opcode in long mode.
- **Prefix orderings.** The runs are 0x66 before W, W before 0x66, an extension prefix followed by a REP or operand-size byte, and two extension prefixes in a row. They tell a correctly placed extension prefix apart from one that must be discarded.
- **Stack opcodes with W = 0 and with 0x66.** These show whether the stack rule overrides the W-bit default.
- **Idle gaps between bytes.** These check that `done` follows only the accepted opcode byte.
- **Byte, 16-bit, 32-bit and 64-bit results written into a register with a known old value.** These tell a merge from a zero-extension.

// File: rtl/isd_pkg.sv
package isd_pkg;

    typedef enum logic [1:0] {
        W16 = 2'd0,
        W32 = 2'd1,
        W64 = 2'd2
    } width_e;

    typedef enum logic {
        S_SCAN    = 1'b0,
        S_EXTPEND = 1'b1
    } state_e;

    typedef struct packed {
        logic w;
        logic r;
        logic x;
        logic b;
    } ext_t;

endpackage

// File: rtl/isd_classify.sv
module isd_classify #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              long_mode,
    output logic              is_legacy,
    output logic              is_opsz,
    output logic              is_adsz,
    output logic              is_ext,
    output logic              is_stack,
    output logic              is_byteop
);
    localparam logic [BYTE_W-1:0] OPSZ_B = BYTE_W'(8'h66);
    localparam logic [BYTE_W-1:0] ADSZ_B = BYTE_W'(8'h67);

    always_comb begin
        is_opsz = (byte_in == OPSZ_B);
        is_adsz = (byte_in == ADSZ_B);
        is_legacy = 1'b0;
        unique case (byte_in)
            BYTE_W'(8'h26), BYTE_W'(8'h2E), BYTE_W'(8'h36), BYTE_W'(8'h3E),
            BYTE_W'(8'h64), BYTE_W'(8'h65), BYTE_W'(8'h66), BYTE_W'(8'h67),
            BYTE_W'(8'hF0), BYTE_W'(8'hF2), BYTE_W'(8'hF3): is_legacy = 1'b1;
            default: is_legacy = 1'b0;
        endcase
        // extension prefix only exists in long mode
        is_ext = long_mode && (byte_in[7:4] == 4'h4);
    end

    always_comb begin
        is_stack = 1'b0;
        if (byte_in[7:4] == 4'h5) begin
            is_stack = 1'b1;
        end else begin
            unique case (byte_in)
                BYTE_W'(8'h68), BYTE_W'(8'h6A), BYTE_W'(8'h8F),
                BYTE_W'(8'h9C), BYTE_W'(8'h9D): is_stack = 1'b1;
                default: is_stack = 1'b0;
            endcase
        end
    end

    always_comb begin
        is_byteop = 1'b0;
        if (byte_in[7:6] == 2'b00) begin
            is_byteop = (byte_in[2:0] == 3'd0) || (byte_in[2:0] == 3'd2) ||
                        (byte_in[2:0] == 3'd4);
        end else if (byte_in[7:3] == 5'b10110) begin
            is_byteop = 1'b1;
        end else begin
            unique case (byte_in)
                BYTE_W'(8'h88), BYTE_W'(8'h8A), BYTE_W'(8'hC6): is_byteop = 1'b1;
                default: is_byteop = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/isd_size_sel.sv
module isd_size_sel
    import isd_pkg::*;
(
    input  logic   long_mode,
    input  logic   opsz_seen,
    input  logic   adsz_seen,
    input  logic   wide_bit,
    input  logic   stack_cls,
    output width_e op_w,
    output width_e addr_w
);
    always_comb begin
        if (long_mode) begin
            addr_w = adsz_seen ? W32 : W64;
            if (wide_bit)       op_w = W64;
            else if (opsz_seen) op_w = W16;
            else if (stack_cls) op_w = W64;
            else                op_w = W32;
        end else begin
            addr_w = adsz_seen ? W16 : W32;
            op_w   = opsz_seen ? W16 : W32;
        end
    end
endmodule

// File: rtl/isd_wb_merge.sv
module isd_wb_merge
    import isd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] res_val,
    input  width_e            width,
    input  logic              byte_sel,
    output logic [DATA_W-1:0] new_val
);
    localparam int HALF_W = DATA_W / 2;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    always_comb begin
        new_val = old_val;
        if (byte_sel) begin
            new_val[BYTE_W-1:0] = res_val[BYTE_W-1:0];
        end else begin
            unique case (width)
                W16:     new_val[WORD_W-1:0] = res_val[WORD_W-1:0];
                W32:     new_val = {{(DATA_W-HALF_W){1'b0}}, res_val[HALF_W-1:0]};
                W64:     new_val = res_val;
                default: new_val = old_val;
            endcase
        end
    end
endmodule

// File: rtl/insn_size_decoder.sv
module insn_size_decoder
    import isd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              long_mode,
    input  logic [DATA_W-1:0] wb_old,
    input  logic [DATA_W-1:0] wb_res,
    output logic              done,
    output logic [BYTE_W-1:0] opcode,
    output logic [1:0]        op_size,
    output logic [1:0]        addr_size,
    output logic              ext_w,
    output logic              ext_r,
    output logic              ext_x,
    output logic              ext_b,
    output logic              stack_op,
    output logic              byte_op,
    output logic [DATA_W-1:0] wb_out
);
    localparam int EXT_W = $bits(ext_t);

    state_e state_q, state_n;
    logic   opsz_q, opsz_n;
    logic   adsz_q, adsz_n;
    ext_t   ext_q, ext_n;

    logic   c_legacy, c_opsz, c_adsz, c_ext, c_stack, c_byteop;
    logic   take_opc;
    ext_t   live_ext;
    width_e sel_op, sel_addr;

    isd_classify #(.BYTE_W(BYTE_W)) u_cls (
        .byte_in   (byte_in),
        .long_mode (long_mode),
        .is_legacy (c_legacy),
        .is_opsz   (c_opsz),
        .is_adsz   (c_adsz),
        .is_ext    (c_ext),
        .is_stack  (c_stack),
        .is_byteop (c_byteop)
    );

    assign take_opc = byte_vld && !c_legacy && !c_ext;
    assign live_ext = (state_q == S_EXTPEND) ? ext_q : '0;

    isd_size_sel u_sel (
        .long_mode (long_mode),
        .opsz_seen (opsz_q),
        .adsz_seen (adsz_q),
        .wide_bit  (live_ext.w),
        .stack_cls (c_stack),
        .op_w      (sel_op),
        .addr_w    (sel_addr)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        opsz_n  = opsz_q;
        adsz_n  = adsz_q;
        ext_n   = ext_q;
        if (byte_vld) begin
            unique case (state_q)
                S_SCAN: begin
                    if (c_legacy) begin               // scan_legacy
                        opsz_n = opsz_q | c_opsz;
                        adsz_n = adsz_q | c_adsz;
                    end else if (c_ext) begin         // scan_ext
                        ext_n   = ext_t'(byte_in[EXT_W-1:0]);
                        state_n = S_EXTPEND;
                    end else begin                    // finish
                        opsz_n = 1'b0;
                        adsz_n = 1'b0;
                        ext_n  = '0;
                    end
                end
                S_EXTPEND: begin
                    if (c_legacy) begin               // pend_drop
                        opsz_n  = opsz_q | c_opsz;
                        adsz_n  = adsz_q | c_adsz;
                        ext_n   = '0;
                        state_n = S_SCAN;
                    end else if (c_ext) begin         // pend_replace
                        ext_n = ext_t'(byte_in[EXT_W-1:0]);
                    end else begin                    // finish
                        opsz_n  = 1'b0;
                        adsz_n  = 1'b0;
                        ext_n   = '0;
                        state_n = S_SCAN;
                    end
                end
                default: state_n = S_SCAN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_SCAN;
            opsz_q  <= 1'b0;
            adsz_q  <= 1'b0;
            ext_q   <= '0;
        end else begin
            state_q <= state_n;
            opsz_q  <= opsz_n;
            adsz_q  <= adsz_n;
            ext_q   <= ext_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            opcode    <= '0;
            op_size   <= 2'd0;
            addr_size <= 2'd0;
            ext_w     <= 1'b0;
            ext_r     <= 1'b0;
            ext_x     <= 1'b0;
            ext_b     <= 1'b0;
            stack_op  <= 1'b0;
            byte_op   <= 1'b0;
        end else begin
            done <= take_opc;
            if (take_opc) begin
                opcode    <= byte_in;
                op_size   <= sel_op;
                addr_size <= sel_addr;
                ext_w     <= live_ext.w;
                ext_r     <= live_ext.r;
                ext_x     <= live_ext.x;
                ext_b     <= live_ext.b;
                stack_op  <= c_stack;
                byte_op   <= c_byteop;
            end
        end
    end

    isd_wb_merge #(.DATA_W(DATA_W)) u_wb (
        .old_val  (wb_old),
        .res_val  (wb_res),
        .width    (width_e'(op_size)),
        .byte_sel (byte_op),
        .new_val  (wb_out)
    );

    // ---------------- assertions ----------------
    p_done_follows_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_vld))
        else $error("done without an accepted byte");

    p_wide_bit_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ext_w) |-> (op_size == 2'd2))
        else $error("W set but width not 64");

    p_compat_no_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(long_mode)) |-> !(ext_w || ext_r || ext_x || ext_b))
        else $error("extension bits in compatibility mode");

    p_stack_not_32_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stack_op && $past(long_mode)) |-> (op_size != 2'd1))
        else $error("stack op at 32 bits in long mode");

    p_long_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(long_mode)) |-> (addr_size != 2'd0))
        else $error("16-bit address in long mode");

    p_zero_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !byte_op && op_size == 2'd1) |-> (wb_out[DATA_W-1:DATA_W/2] == '0))
        else $error("32-bit write not zero-extended");

endmodule

// File: tb/tb_insn_size_decoder.sv
module tb_insn_size_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        long_mode = 1'b1;
    logic [63:0] wb_old = 64'hFEDC_BA98_7654_3210;
    logic [63:0] wb_res = 64'h1122_3344_5566_7788;
    logic        done, ext_w, ext_r, ext_x, ext_b, stack_op, byte_op;
    logic [7:0]  opcode;
    logic [1:0]  op_size, addr_size;
    logic [63:0] wb_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";
    logic [7:0] stim[$];

    always #2.5 clk = ~clk;

    insn_size_decoder dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .long_mode(long_mode), .wb_old(wb_old), .wb_res(wb_res),
        .done(done), .opcode(opcode), .op_size(op_size), .addr_size(addr_size),
        .ext_w(ext_w), .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b),
        .stack_op(stack_op), .byte_op(byte_op), .wb_out(wb_out)
    );

    // behavioural reference model
    int          m_p66 = 0, m_p67 = 0, m_ext = -1;
    logic        e_done = 1'b0;
    logic [7:0]  e_opc = 8'h00;
    int          e_op = 0, e_ad = 0;
    logic [3:0]  e_ext = 4'h0;
    logic        e_stack = 1'b0, e_byte = 1'b0;

    function automatic bit is_legacy_b(input logic [7:0] b);
        return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67,
                         8'hF0, 8'hF2, 8'hF3};
    endfunction

    function automatic bit is_stack_b(input logic [7:0] b);
        return (b >= 8'h50 && b <= 8'h5F) || b inside {8'h68, 8'h6A, 8'h8F, 8'h9C, 8'h9D};
    endfunction

    function automatic bit is_byte_b(input logic [7:0] b);
        if (b < 8'h40) return (b % 8 == 0) || (b % 8 == 2) || (b % 8 == 4);
        return (b >= 8'hB0 && b <= 8'hB7) || b inside {8'h88, 8'h8A, 8'hC6};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p66 = 0; m_p67 = 0; m_ext = -1;
            e_done <= 0; e_opc <= 0; e_op <= 0; e_ad <= 0; e_ext <= 0;
            e_stack <= 0; e_byte <= 0;
        end else begin
            e_done <= 0;
            if (byte_vld) begin
                if (is_legacy_b(byte_in)) begin
                    if (byte_in == 8'h66) m_p66 = 1;
                    if (byte_in == 8'h67) m_p67 = 1;
                    m_ext = -1;
                end else if (long_mode && byte_in[7:4] == 4'h4) begin
                    m_ext = int'(byte_in[3:0]);
                end else begin
                    logic [3:0] x;
                    x = (m_ext < 0) ? 4'h0 : 4'(m_ext);
                    e_done  <= 1;
                    e_opc   <= byte_in;
                    e_ext   <= x;
                    e_stack <= is_stack_b(byte_in);
                    e_byte  <= is_byte_b(byte_in);
                    if (long_mode) begin
                        e_ad <= m_p67 ? 1 : 2;
                        if (x[3]) e_op <= 2;
                        else if (m_p66 != 0) e_op <= 0;
                        else e_op <= is_stack_b(byte_in) ? 2 : 1;
                    end else begin
                        e_ad <= m_p67 ? 0 : 1;
                        e_op <= m_p66 ? 0 : 1;
                    end
                    m_p66 = 0; m_p67 = 0; m_ext = -1;
                end
            end
        end
    end

    function automatic logic [63:0] exp_wb(input logic bsel, input int w);
        if (bsel)   return {wb_old[63:8], wb_res[7:0]};
        if (w == 0) return {wb_old[63:16], wb_res[15:0]};
        if (w == 1) return {32'h0, wb_res[31:0]};
        return wb_res;
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("done", 64'(done), 64'(e_done));
            if (e_done) begin
                chk("opcode", 64'(opcode), 64'(e_opc));
                chk("op_size", 64'(op_size), 64'(e_op));
                chk("addr_size", 64'(addr_size), 64'(e_ad));
                chk("ext", 64'({ext_w, ext_r, ext_x, ext_b}), 64'(e_ext));
                chk("stack_op", 64'(stack_op), 64'(e_stack));
                chk("byte_op", 64'(byte_op), 64'(e_byte));
                chk("wb_out", wb_out, exp_wb(e_byte, e_op));
            end
        end
    end

    task automatic send(input string req, input bit gap);
        cur_req = req;
        foreach (stim[i]) begin
            @(posedge clk); #1;
            byte_vld = 1'b1;
            byte_in  = stim[i];
            if (gap) begin
                @(posedge clk); #1;
                byte_vld = 1'b0;
                byte_in  = 8'h66;
            end
        end
        @(posedge clk); #1;
        byte_vld = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("reset done", 64'(done), 64'd0);
        chk("reset fields", 64'({opcode, op_size, addr_size, ext_w, ext_r, ext_x, ext_b,
                                  stack_op, byte_op}), 64'd0);

        long_mode = 1'b1;
        stim = '{8'h01};               send("R2", 0);
        stim = '{8'h48, 8'h01};        send("R3", 0);
        stim = '{8'h66, 8'h48, 8'h01}; send("R3", 0);
        stim = '{8'h66, 8'h01};        send("R4", 0);
        stim = '{8'h48, 8'h66, 8'h01}; send("R5", 0);
        stim = '{8'h41, 8'hF3, 8'h01}; send("R5", 0);
        stim = '{8'h4D, 8'h03};        send("R8", 0);
        stim = '{8'h46, 8'h8B};        send("R8", 0);
        stim = '{8'h4F, 8'h42, 8'h01}; send("R8", 0);
        stim = '{8'h50};               send("R7", 0);
        stim = '{8'h40, 8'h58};        send("R7", 0);
        stim = '{8'h66, 8'h6A};        send("R7", 0);
        stim = '{8'h67, 8'h01};        send("R9", 0);
        stim = '{8'h67, 8'h48, 8'h8B}; send("R10", 1);
        stim = '{8'h01, 8'h03, 8'h9C}; send("R10", 0);

        stim = '{8'h00};               send("R11", 0);
        stim = '{8'h66, 8'h01};        send("R11", 0);
        stim = '{8'h01};               send("R11", 0);
        stim = '{8'h48, 8'h01};        send("R11", 0);
        stim = '{8'hB3};               send("R11", 0);

        long_mode = 1'b0;
        stim = '{8'h40};               send("R6", 0);
        stim = '{8'h66, 8'h48};        send("R6", 0);
        stim = '{8'h67, 8'h01};        send("R6", 0);
        stim = '{8'h50};               send("R6", 0);
        stim = '{8'h66, 8'h4F, 8'h01}; send("R6", 0);

        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                finish_run();
            end
        end
    end
endmodule